// File: doc/BRIEF.md
# Half-Duplex Host Serial Link with Reset-Latched Baud Select

This block connects the modem core to an external application controller over an asynchronous serial line. The line has one receive pin and one transmit pin. Each character is framed as 8N1: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line rests high between characters. On the core side there is a byte-wide valid/ready pair for each direction. The link is half duplex. A character is never sent while one is being received, and the reverse also holds. A request line from the host decides whether the local transmitter may use the line.

Two strap inputs pick one of four bit rates. They are read once, on the first clock after reset is released. A new rate therefore needs the straps to be set and a reset to be applied. The receiver samples the line sixteen times per bit and takes a majority vote of the three centre samples. It flags a bad stop bit, and it keeps a sticky flag when a new byte arrives before the core has taken the previous one.

Top module: `host_uart_link`

## Requirements
- R1: After reset, `txd` is high and `rxValid`, `frameErr` and `overrun` are low. On the third clock after reset is released, `txReady` is high.
- R2: `baudSel` is captured on the first rising clock edge after `rstN` goes high. Changes after that edge have no effect until the next reset. One bit lasts 16 × D × 2^(3−code) clocks, where D = CLK_HZ / (BASE_BAUD × 128). Code 2'b11 is the fastest rate and 2'b00 the slowest.
- R3: An accepted byte is sent as a start bit (0), then data bits 0 to 7, then a stop bit (1), each exactly one bit period long. The start bit begins in the cycle that follows the accepting clock edge.
- R4: `txReady` is high only when all three of these hold: the transmitter is idle, the synchronized `hostReq` is low, and the receiver is idle. A byte is taken on a clock edge where `txValid` and `txReady` are both high.
- R5: While `hostReq` is high, `txd` stays high and `txReady` stays low. A byte held on `txValid` is sent after `hostReq` is released.
- R6: A received byte appears on `rxData` with `rxValid` high. `rxValid` stays high until a clock edge where `rxReady` is high.
- R7: `frameErr` is updated with every delivered byte. It is 1 when the majority-voted stop bit was 0 and 0 otherwise. The byte is delivered in both cases.
- R8: When a byte is delivered while `rxValid` is still high and `rxReady` is low, `overrun` goes high. The new byte replaces the old one. `overrun` stays high until reset.
- R9: A falling edge on `rxd` while a byte is being sent does not start a reception, so no byte is delivered from it.
- R10: A low pulse on `rxd` shorter than half a bit is rejected as a false start, and no byte is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudSel | input | 2 | Rate strap, captured once after reset |
| hostReq | input | 1 | Host request; high means the host owns the line |
| rxd | input | 1 | Serial receive line, idles high |
| txd | output | 1 | Serial transmit line, idles high |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | `txData` holds a byte to send |
| txReady | output | 1 | Transmitter can accept a byte |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | `rxData` holds an unconsumed byte |
| rxReady | input | 1 | Core takes the received byte |
| frameErr | output | 1 | Stop bit of the delivered byte was low |
| overrun | output | 1 | Sticky: a byte arrived before the previous one was taken |

## Verification
The bench derives the bit period from the strap code it applied. From the capture, it samples `txd` half a bit after the falling edge it sees, then once per bit period. This lands in the middle of each bit whatever the divider phase is.

For reception, `rxValid`, `rxData` and `frameErr` are due within two synchronizer clocks plus one sample tick after the end of the stop bit. The bench reads them only after two further idle bit periods. `rxValid` clearing is due one clock after an `rxReady` pulse and is read on the following falling edge. The effect of `hostReq` is due two clocks after it changes, and the bench waits four clocks before observing `txReady`.

// File: rtl/host_uart_pkg.sv
package host_uart_pkg;

  // Per-cycle strobes from the sequencing logic to the shift/sample datapath.
  typedef struct packed {
    logic rxSample;   // capture one of the three centre samples
    logic rxShift;    // shift the voted data bit into the receive register
    logic rxDeliver;  // stop bit voted: publish the received byte
    logic txLoad;     // load a new frame into the transmit register
    logic txShift;    // advance the transmit register by one bit
  } linkStrobes_t;

endpackage

// File: rtl/host_uart_ctrl.sv
module host_uart_ctrl
  import host_uart_pkg::*;
#(
  parameter int CLK_HZ    = 24_000_000,
  parameter int BASE_BAUD = 4800,
  parameter int OVS       = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   baudSel,
  input  logic         rxSync,
  input  logic         reqSync,
  input  logic         rxMajority,
  input  logic         txValid,
  output logic         txReady,
  output linkStrobes_t strobes
);

  // Tick divisor at the fastest rate; slower codes double it per step.
  localparam int DIV_FAST = CLK_HZ / (BASE_BAUD * OVS * 8);
  localparam int DIVW     = $clog2(DIV_FAST * 8 + 1);
  localparam int SUBW     = $clog2(OVS);
  localparam logic [SUBW-1:0] SUB_LAST  = SUBW'(OVS - 1);
  localparam logic [SUBW-1:0] SUB_EARLY = SUBW'(OVS / 2 - 1);
  localparam logic [SUBW-1:0] SUB_MID   = SUBW'(OVS / 2);
  localparam logic [SUBW-1:0] SUB_LATE  = SUBW'(OVS / 2 + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  logic            armed;
  logic [1:0]      baudCode;
  logic [DIVW-1:0] divisor;
  logic [DIVW-1:0] divCnt;
  logic            tick;
  rxState_t        rxState;
  logic [SUBW-1:0] rxSub;
  logic [2:0]      rxBit;
  logic            rxStart;
  logic            txBusy;
  logic [SUBW-1:0] txSub;
  logic [3:0]      txBit;
  logic            txAccept;

  // Strap capture: one shot on the first edge after reset release.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      baudCode <= 2'b00;
    end else if (!armed) begin
      armed    <= 1'b1;
      baudCode <= baudSel;
    end
  end

  always_comb divisor = DIVW'(DIV_FAST) << (2'd3 - baudCode);

  // Oversampling tick; realigned when a transmission starts so every
  // transmitted bit spans exactly OVS ticks.
  assign tick = (divCnt == divisor - DIVW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              divCnt <= '0;
    else if (txAccept || tick) divCnt <= '0;
    else                    divCnt <= divCnt + DIVW'(1);
  end

  // Direction arbitration.
  assign txReady  = armed && !txBusy && (rxState == RX_IDLE) && !reqSync;
  assign txAccept = txValid && txReady;
  assign rxStart  = armed && tick && !rxSync && !txBusy && !txAccept;

  // Receive sequencer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxSub   <= '0;
      rxBit   <= '0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (rxStart) begin
            rxState <= RX_START;
            rxSub   <= '0;
          end
        end
        default: begin
          if (tick) begin
            rxSub <= rxSub + SUBW'(1);
            if (rxSub == SUB_LAST) begin
              case (rxState)
                RX_START: begin
                  if (!rxMajority) begin
                    rxState <= RX_DATA;
                    rxBit   <= '0;
                  end else begin
                    rxState <= RX_IDLE;
                  end
                end
                RX_DATA: begin
                  rxBit <= rxBit + 3'd1;
                  if (rxBit == 3'd7) rxState <= RX_STOP;
                end
                default: rxState <= RX_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  // Transmit sequencer: ten bits of OVS ticks each.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txSub  <= '0;
      txBit  <= '0;
    end else if (txAccept) begin
      txBusy <= 1'b1;
      txSub  <= '0;
      txBit  <= '0;
    end else if (txBusy && tick) begin
      txSub <= txSub + SUBW'(1);
      if (txSub == SUB_LAST) begin
        txBit <= txBit + 4'd1;
        if (txBit == 4'd9) txBusy <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.rxSample  = tick && (rxState != RX_IDLE) &&
                        (rxSub == SUB_EARLY || rxSub == SUB_MID || rxSub == SUB_LATE);
    strobes.rxShift   = tick && (rxState == RX_DATA) && (rxSub == SUB_LAST);
    strobes.rxDeliver = tick && (rxState == RX_STOP) && (rxSub == SUB_LAST);
    strobes.txLoad    = txAccept;
    strobes.txShift   = tick && txBusy && (txSub == SUB_LAST);
  end

  // R9: the two directions never run together.
  a_r9_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    !(txBusy && rxState != RX_IDLE));

  // R5: an idle transmitter stays idle while the host holds the request.
  a_r5_hold_while_req: assert property (@(posedge clk) disable iff (!rstN)
    (reqSync && !txBusy) |=> !txBusy);

  // R2: once captured, the rate code never moves.
  a_r2_code_frozen: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> (armed && $stable(baudCode)));

endmodule

// File: rtl/host_uart_datapath.sv
module host_uart_datapath
  import host_uart_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxd,
  input  logic         hostReq,
  input  linkStrobes_t strobes,
  input  logic [7:0]   txData,
  input  logic         rxReady,
  output logic         rxSync,
  output logic         reqSync,
  output logic         rxMajority,
  output logic         txd,
  output logic [7:0]   rxData,
  output logic         rxValid,
  output logic         frameErr,
  output logic         overrun
);

  logic       rxMeta;
  logic       reqMeta;
  logic [2:0] samples;
  logic [7:0] rxShiftReg;
  logic [9:0] txShiftReg;

  // Two-stage synchronizers; the line synchronizer rests at the idle level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxSync  <= 1'b1;
      reqMeta <= 1'b0;
      reqSync <= 1'b0;
    end else begin
      rxMeta  <= rxd;
      rxSync  <= rxMeta;
      reqMeta <= hostReq;
      reqSync <= reqMeta;
    end
  end

  // Three centre samples and their majority.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 samples <= 3'b111;
    else if (strobes.rxSample) samples <= {samples[1:0], rxSync};
  end

  assign rxMajority = (samples[0] & samples[1]) | (samples[1] & samples[2]) |
                      (samples[0] & samples[2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rxShiftReg <= '0;
    else if (strobes.rxShift) rxShiftReg <= {rxMajority, rxShiftReg[7:1]};
  end

  // Receive output register with consume handshake and sticky overrun.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxValid  <= 1'b0;
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end else if (strobes.rxDeliver) begin
      rxData   <= rxShiftReg;
      rxValid  <= 1'b1;
      frameErr <= !rxMajority;
      if (rxValid && !rxReady) overrun <= 1'b1;
    end else if (rxValid && rxReady) begin
      rxValid <= 1'b0;
    end
  end

  // Transmit register: stop, data, start; shifts in idle ones.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                txShiftReg <= '1;
    else if (strobes.txLoad)  txShiftReg <= {1'b1, txData, 1'b0};
    else if (strobes.txShift) txShiftReg <= {1'b1, txShiftReg[9:1]};
  end

  assign txd = txShiftReg[0];

  // R8: overrun is sticky until reset.
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R6: an unconsumed byte stays valid.
  a_r6_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> rxValid);

  // R3: a frame opens with a low start bit right after the load.
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txLoad |=> !txd);

endmodule

// File: rtl/host_uart_link.sv
module host_uart_link
  import host_uart_pkg::*;
#(
  parameter int CLK_HZ    = 24_000_000,
  parameter int BASE_BAUD = 4800,
  parameter int OVS       = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] baudSel,
  input  logic       hostReq,
  input  logic       rxd,
  output logic       txd,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic [7:0] rxData,
  output logic       rxValid,
  input  logic       rxReady,
  output logic       frameErr,
  output logic       overrun
);

  linkStrobes_t strobes;
  logic         rxSync;
  logic         reqSync;
  logic         rxMajority;

  host_uart_ctrl #(
    .CLK_HZ   (CLK_HZ),
    .BASE_BAUD(BASE_BAUD),
    .OVS      (OVS)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .baudSel   (baudSel),
    .rxSync    (rxSync),
    .reqSync   (reqSync),
    .rxMajority(rxMajority),
    .txValid   (txValid),
    .txReady   (txReady),
    .strobes   (strobes)
  );

  host_uart_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .rxd       (rxd),
    .hostReq   (hostReq),
    .strobes   (strobes),
    .txData    (txData),
    .rxReady   (rxReady),
    .rxSync    (rxSync),
    .reqSync   (reqSync),
    .rxMajority(rxMajority),
    .txd       (txd),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .frameErr  (frameErr),
    .overrun   (overrun)
  );

endmodule

// File: tb/host_uart_link_test.sv
module host_uart_link_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] baudSel = 2'b11;
  logic       hostReq = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic       txReady;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxReady = 1'b0;
  logic       frameErr;
  logic       overrun;

  int nChecks = 0;
  int nFail = 0;
  int bitCyc = 32;
  logic [1:0] curCode = 2'b11;

  // {code[1:0], isTx, badStop, data[7:0]}
  localparam logic [11:0] VEC [12] = '{
    12'hCA5, 12'hE3C, 12'hD0F, 12'hE81,
    12'h800, 12'hAFF, 12'h45A, 12'h6C3,
    12'h57E, 12'h296, 12'h069, 12'h0FF
  };

  always #4 clk = ~clk;

  // Fastest-rate divisor is 2 with this clock: bit = 16*2*2^(3-code) cycles.
  host_uart_link #(.CLK_HZ(1_228_800)) uut (
    .clk(clk), .rstN(rstN), .baudSel(baudSel), .hostReq(hostReq), .rxd(rxd),
    .txd(txd), .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .frameErr(frameErr), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] code);
    @(negedge clk);
    rstN = 1'b0; baudSel = code; txValid = 1'b0; rxReady = 1'b0;
    hostReq = 1'b0; rxd = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    curCode = code;
    bitCyc = 256 >> code;
  endtask

  task automatic sendRx(input logic [7:0] d, input logic stopBit, output logic midReady);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bitCyc / 2) @(negedge clk);
    midReady = txReady;
    repeat (bitCyc - bitCyc / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bitCyc) @(negedge clk);
    end
    rxd = stopBit;
    repeat (bitCyc) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bitCyc) @(negedge clk);
  endtask

  task automatic pulseConsume();
    @(negedge clk); rxReady = 1'b1;
    @(negedge clk); rxReady = 1'b0;
  endtask

  task automatic txByte(input logic [7:0] d, output logic [7:0] got,
                        output logic startV, output logic stopV, output logic busyReady);
    int n;
    n = 0;
    txData = d;
    txValid = 1'b1;
    while (txd !== 1'b0 && n < 8192) begin
      @(negedge clk);
      n++;
    end
    txValid = 1'b0;
    repeat (bitCyc / 2) @(negedge clk);
    startV = txd;
    busyReady = txReady;
    for (int i = 0; i < 8; i++) begin
      repeat (bitCyc) @(negedge clk);
      got[i] = txd;
    end
    repeat (bitCyc) @(negedge clk);
    stopV = txd;
    repeat (bitCyc) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [11:0] v;
    logic [7:0]  got;
    logic        startV, stopV, busyR, midR;
    int          viol;

    doReset(2'b11);
    // R1 reset state
    chk("R1 txd idle", txd, 1);
    chk("R1 rxValid", rxValid, 0);
    chk("R1 frameErr", frameErr, 0);
    chk("R1 overrun", overrun, 0);
    chk("R4 ready when idle", txReady, 1);

    // Vector table: rates, both directions, stop-bit quality.
    for (int k = 0; k < 12; k++) begin
      v = VEC[k];
      if (v[11:10] != curCode) doReset(v[11:10]);
      if (v[9]) begin
        txByte(v[7:0], got, startV, stopV, busyR);
        chk("R2/R3 tx data", got, v[7:0]);
        chk("R3 start bit", startV, 0);
        chk("R3 stop bit", stopV, 1);
        chk("R4 ready low while sending", busyR, 0);
      end else begin
        sendRx(v[7:0], !v[8], midR);
        chk("R2/R6 rx valid", rxValid, 1);
        chk("R6 rx data", rxData, v[7:0]);
        chk("R7 frame error", frameErr, v[8]);
        chk("R4 ready low while receiving", midR, 0);
        pulseConsume();
        chk("R6 consumed", rxValid, 0);
      end
    end

    // R2: strap change after reset is ignored.
    doReset(2'b01);
    @(negedge clk); baudSel = 2'b11;
    repeat (10) @(negedge clk);
    txByte(8'h55, got, startV, stopV, busyR);
    chk("R2 rate kept after strap change", got, 8'h55);
    chk("R2 stop at kept rate", stopV, 1);

    // R5: host request holds the transmitter.
    doReset(2'b11);
    @(negedge clk); hostReq = 1'b1;
    repeat (4) @(negedge clk);
    txData = 8'hA7; txValid = 1'b1;
    viol = 0;
    for (int i = 0; i < 4 * bitCyc; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || txReady !== 1'b0) viol++;
    end
    chk("R5 line held during request", viol, 0);
    hostReq = 1'b0;
    txByte(8'hA7, got, startV, stopV, busyR);
    chk("R5 queued byte sent after release", got, 8'hA7);

    // R9: receive edge during transmission is ignored.
    fork
      txByte(8'h5A, got, startV, stopV, busyR);
      begin
        while (txd !== 1'b0) @(negedge clk);
        repeat (2 * bitCyc) @(negedge clk);
        rxd = 1'b0;
        repeat (6 * bitCyc) @(negedge clk);
        rxd = 1'b1;
      end
    join
    repeat (3 * bitCyc) @(negedge clk);
    chk("R9 tx unaffected", got, 8'h5A);
    chk("R9 no byte from rx during tx", rxValid, 0);

    // R10: short glitch is a false start; a real frame still follows.
    @(negedge clk); rxd = 1'b0;
    repeat (bitCyc / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bitCyc) @(negedge clk);
    chk("R10 glitch rejected", rxValid, 0);
    sendRx(8'h3C, 1'b1, midR);
    chk("R10 frame after glitch", rxData, 8'h3C);
    pulseConsume();

    // R8: overrun is sticky and newest byte wins.
    sendRx(8'h11, 1'b1, midR);
    chk("R8 no overrun on first byte", overrun, 0);
    sendRx(8'h22, 1'b1, midR);
    chk("R8 overrun set", overrun, 1);
    chk("R8 newest byte kept", rxData, 8'h22);
    pulseConsume();
    chk("R8 overrun sticky after consume", overrun, 1);
    chk("R6 consumed after overrun", rxValid, 0);
    doReset(2'b11);
    chk("R1/R8 overrun cleared by reset", overrun, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule